// File: doc/BRIEF.md
# T1 Transmit Time-Slot Indicator

This block follows the bit position inside each outgoing 193-bit T1 frame and reports which payload time slot the transmit payload input is accepting. Each frame starts with one framing bit, followed by 24 slots of 8 bits each, sent MSB first. The block also produces a per-slot strobe, a frame sync and a multiframe sync. A timing-source select decides how the sync signals behave. With the terminal-equipment source they are inputs, and the counters realign to the sampled pulses. With the local-oscillator source or the recovered line source the block drives them.

A mode bit changes the role of the five indicator pins at run time. In normal mode the pins carry the slot number as a parallel binary value. In fractional mode the pins take the following roles:
- pin 0 is the fractional payload input;
- pin 1 is the robbed-bit signalling input;
- pin 2 shifts out the slot number serially;
- pin 3 marks the start of each multiframe.

In fractional mode the strobe becomes a gapped enable, qualified by a 24-bit slot mask. Every pin has an output-enable, so the chip pad ring can turn it around. All logic runs on the serial bit clock, and a synchronous reset places the counters at the framing bit of frame 0.

Top module: `t1_slot_indicator`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the block sits at the framing bit of frame 0: `sync_out`=1, `msync_out`=1, `ind_out`=0 in normal mode, and `ts_strobe`=0.
- R2: With an internal timing source, a frame lasts 193 bit clocks. `sync_out` is high only in the framing-bit cycle. The next cycle is the MSB (bit 0) of slot 0, and each slot lasts 8 cycles.
- R3: When `frac_en`=0, `ind_oe`=5'b11111 and `ind_out` holds the current slot number 0..23 in binary, with bit 4 as MSB. `ind_out` reads 0 during the framing bit.
- R4: When `frac_en`=0, `ts_strobe` is high exactly in the eighth (LSB) cycle of every slot. This gives 24 pulses per frame and never a pulse in the framing bit.
- R5: When `frac_en`=1, `ind_oe`=5'b01100: pins 2 and 3 drive, and pins 0, 1 and 4 are undriven. Bits 0, 1 and 4 of `ind_out` read 0.
- R6: When `frac_en`=1, `ts_strobe` is high in every cycle of a slot whose bit is set in `slot_mask` (bit n selects slot n). It is low in the framing bit. `frac_vld` equals that enable, and `frac_bit` equals `pin_in[0]` when `frac_vld` is high and 0 otherwise.
- R7: When `frac_en`=1, `ind_out[2]` carries the slot number serially. During cycles 0..4 of a slot it shows bits 4..0 in that order (MSB first). It is 0 in cycles 5..7 of the slot and in the framing bit.
- R8: When `frac_en`=1, `ind_out[3]` is high only in the framing-bit cycle of frame 0 of the multiframe.
- R9: A multiframe has 12 frames when `esf_mode`=0 and 24 frames when `esf_mode`=1. `msync_out` is high only in the framing bit of frame 0.
- R10: When `frac_en`=1, `sig_vld` is high in the LSB cycle of every slot in frames whose index satisfies index mod 6 = 5 (counting from 0). `sig_bit` equals `pin_in[1]` when `sig_vld` is high and 0 otherwise.
- R11: `timing_src`=0 selects terminal-equipment timing: `sync_drive`=0 and the sync inputs are used. Values 1 (oscillator), 2 (recovered line) and 3 (reserved) give `sync_drive`=1, and `sync_in`/`msync_in` then have no effect.
- R12: Under terminal-equipment timing, a cycle with `sync_in`=1 is taken as a framing bit, so the next cycle is bit 0 of slot 0. If `msync_in`=1 in the same cycle, the new frame is frame 0. Otherwise the frame index is kept if the block was already at a framing bit, and advanced by one (with multiframe wrap) if it was not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_src | input | 2 | 0 terminal equipment, 1 oscillator, 2 recovered line |
| frac_en | input | 1 | 1 selects fractional pin roles |
| esf_mode | input | 1 | 0 for a 12-frame multiframe, 1 for a 24-frame multiframe |
| slot_mask | input | 24 | Fractional slot selection, bit n for slot n |
| sync_in | input | 1 | Sampled frame sync (terminal timing) |
| msync_in | input | 1 | Sampled multiframe sync (terminal timing) |
| pin_in | input | 2 | Pad inputs of indicator pins 1 and 0 |
| ind_out | output | 5 | Indicator pin output values |
| ind_oe | output | 5 | Indicator pin output enables |
| ts_strobe | output | 1 | Slot LSB strobe, or gapped enable in fractional mode |
| sync_out | output | 1 | Frame sync (framing-bit cycle) |
| msync_out | output | 1 | Multiframe sync |
| sync_drive | output | 1 | Output-enable for the clock and sync pads |
| frac_vld | output | 1 | Fractional payload bit accepted this cycle |
| frac_bit | output | 1 | Accepted fractional payload bit |
| sig_vld | output | 1 | Signalling bit accepted this cycle |
| sig_bit | output | 1 | Accepted signalling bit |

## Verification
Free-running internal timing in both multiframe lengths checks the frame length, the slot stepping and the multiframe length. Normal and fractional modes each run over full multiframes, which tells the parallel slot number apart from the serial number and the overhead pulse. Three slot masks are used: a sparse irregular mask, all zeros and all ones. Together they show whether the gapped enable follows the mask bit of the right slot or just passes a constant. Randomised values on the two input pins separate data capture from gating. Sync pulses are injected mid-frame, at a framing bit and with the multiframe flag, and then again with an internal source, which shows realignment under terminal timing and shows that it is ignored otherwise.

// File: rtl/t1si_pkg.sv
package t1si_pkg;
   typedef enum logic [1:0] {
      SRC_TERM = 2'd0,
      SRC_OSC  = 2'd1,
      SRC_LINE = 2'd2,
      SRC_RSVD = 2'd3
   } tsrc_e;
endpackage

// File: rtl/t1si_timebase.sv
module t1si_timebase #(
   parameter int SLOTS     = 24,
   parameter int SLOT_BITS = 8,
   parameter int MF_SHORT  = 12,
   parameter int MF_LONG   = 24,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int BIT_W    = $clog2(SLOT_BITS),
   localparam int MF_W     = $clog2(MF_LONG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              esf_mode,
   input  logic              realign,
   input  logic              realign_mf,
   output logic              fbit_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [BIT_W-1:0]  bit_o,
   output logic [MF_W-1:0]   frame_o
);
   localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

   logic              fbit_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;
   logic [MF_W-1:0]   frame_q;
   logic [MF_W-1:0]   frame_inc;
   int                mf_len;

   always_comb begin
      mf_len = esf_mode ? MF_LONG : MF_SHORT;
      if (int'(frame_q) + 1 >= mf_len) frame_inc = '0;
      else                             frame_inc = frame_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fbit_q  <= 1'b1;
         slot_q  <= '0;
         bit_q   <= '0;
         frame_q <= '0;
      end else if (realign) begin
         fbit_q <= 1'b0;
         slot_q <= '0;
         bit_q  <= '0;
         if (realign_mf)  frame_q <= '0;
         else if (!fbit_q) frame_q <= frame_inc;
      end else if (fbit_q) begin
         fbit_q <= 1'b0;
         slot_q <= '0;
         bit_q  <= '0;
      end else if (bit_q == BIT_LAST) begin
         bit_q <= '0;
         if (slot_q == SLOT_LAST) begin
            fbit_q  <= 1'b1;
            slot_q  <= '0;
            frame_q <= frame_inc;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end else begin
         bit_q <= bit_q + 1'b1;
      end
   end

   assign fbit_o  = fbit_q;
   assign slot_o  = slot_q;
   assign bit_o   = bit_q;
   assign frame_o = frame_q;
endmodule

// File: rtl/t1si_syncif.sv
module t1si_syncif #(
   parameter int MF_W = 5
) (
   input  logic [1:0]      timing_src,
   input  logic            sync_in,
   input  logic            msync_in,
   input  logic            fbit,
   input  logic [MF_W-1:0] frame,
   output logic            realign,
   output logic            realign_mf,
   output logic            sync_out,
   output logic            msync_out,
   output logic            sync_drive
);
   import t1si_pkg::*;
   logic ext_timed;

   always_comb begin
      ext_timed  = (tsrc_e'(timing_src) == SRC_TERM);
      sync_drive = !ext_timed;
      realign    = ext_timed && sync_in;
      realign_mf = realign && msync_in;
      sync_out   = fbit;
      msync_out  = fbit && (frame == '0);
   end
endmodule

// File: rtl/t1si_pinmux.sv
module t1si_pinmux #(
   parameter int SLOTS      = 24,
   parameter int SLOT_BITS  = 8,
   parameter int NUM_W      = 5,
   parameter int SIG_PERIOD = 6,
   parameter int SLOT_W     = $clog2(SLOTS),
   parameter int BIT_W      = $clog2(SLOT_BITS),
   parameter int MF_W       = 5
) (
   input  logic              frac_en,
   input  logic              fbit,
   input  logic              mf_first,
   input  logic [SLOT_W-1:0] slot,
   input  logic [BIT_W-1:0]  bitn,
   input  logic [MF_W-1:0]   frame,
   input  logic [SLOTS-1:0]  slot_mask,
   input  logic [1:0]        pin_in,
   output logic [NUM_W-1:0]  pin_out,
   output logic [NUM_W-1:0]  pin_oe,
   output logic              strobe,
   output logic              frac_vld,
   output logic              frac_bit,
   output logic              sig_vld,
   output logic              sig_bit
);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);
   localparam int PIN_SER  = 2;
   localparam int PIN_OHS  = 3;

   logic [NUM_W-1:0] slot_wide;
   logic [NUM_W-1:0] frac_role;
   logic             lsb_cyc, slot_sel, ser_bit, sig_frame;

   always_comb begin
      slot_wide = NUM_W'(slot);
      lsb_cyc   = !fbit && (bitn == BIT_LAST);
      slot_sel  = !fbit && slot_mask[slot];
      ser_bit   = 1'b0;
      if (!fbit && int'(bitn) < NUM_W)
         ser_bit = slot_wide[NUM_W - 1 - int'(bitn)];
      sig_frame = (int'(frame) % SIG_PERIOD) == SIG_PERIOD - 1;
      frac_role          = '0;
      frac_role[PIN_SER] = ser_bit;
      frac_role[PIN_OHS] = mf_first;
   end

   for (genvar k = 0; k < NUM_W; k++) begin : g_pin
      if (k == PIN_SER || k == PIN_OHS) begin : g_drv
         assign pin_oe[k]  = 1'b1;
         assign pin_out[k] = frac_en ? frac_role[k] : slot_wide[k];
      end else begin : g_turn
         assign pin_oe[k]  = !frac_en;
         assign pin_out[k] = frac_en ? 1'b0 : slot_wide[k];
      end
   end

   always_comb begin
      strobe   = frac_en ? slot_sel : lsb_cyc;
      frac_vld = frac_en && slot_sel;
      frac_bit = frac_vld && pin_in[0];
      sig_vld  = frac_en && lsb_cyc && sig_frame;
      sig_bit  = sig_vld && pin_in[1];
   end
endmodule

// File: rtl/t1_slot_indicator.sv
module t1_slot_indicator #(
   parameter int SLOTS      = 24,
   parameter int SLOT_BITS  = 8,
   parameter int MF_SHORT   = 12,
   parameter int MF_LONG    = 24,
   parameter int NUM_W      = 5,
   parameter int SIG_PERIOD = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       timing_src,
   input  logic             frac_en,
   input  logic             esf_mode,
   input  logic [SLOTS-1:0] slot_mask,
   input  logic             sync_in,
   input  logic             msync_in,
   input  logic [1:0]       pin_in,
   output logic [NUM_W-1:0] ind_out,
   output logic [NUM_W-1:0] ind_oe,
   output logic             ts_strobe,
   output logic             sync_out,
   output logic             msync_out,
   output logic             sync_drive,
   output logic             frac_vld,
   output logic             frac_bit,
   output logic             sig_vld,
   output logic             sig_bit
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int MF_W   = $clog2(MF_LONG);

   initial begin
      if (NUM_W < SLOT_W || NUM_W < 4)
         $error("indicator width too small for slot number or pin roles");
      if (MF_SHORT > MF_LONG || MF_LONG % SIG_PERIOD != 0)
         $error("multiframe lengths inconsistent");
      if ((1 << BIT_W) != SLOT_BITS)
         $error("slot bit count must be a power of two");
   end

   logic              fbit;
   logic [SLOT_W-1:0] slot;
   logic [BIT_W-1:0]  bitn;
   logic [MF_W-1:0]   frame;
   logic              realign, realign_mf;

   t1si_timebase #(
      .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .MF_SHORT(MF_SHORT), .MF_LONG(MF_LONG)
   ) u_tb (
      .clk(clk), .rst(rst), .esf_mode(esf_mode),
      .realign(realign), .realign_mf(realign_mf),
      .fbit_o(fbit), .slot_o(slot), .bit_o(bitn), .frame_o(frame)
   );

   t1si_syncif #(.MF_W(MF_W)) u_sync (
      .timing_src(timing_src), .sync_in(sync_in), .msync_in(msync_in),
      .fbit(fbit), .frame(frame),
      .realign(realign), .realign_mf(realign_mf),
      .sync_out(sync_out), .msync_out(msync_out), .sync_drive(sync_drive)
   );

   t1si_pinmux #(
      .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .NUM_W(NUM_W),
      .SIG_PERIOD(SIG_PERIOD), .SLOT_W(SLOT_W), .BIT_W(BIT_W), .MF_W(MF_W)
   ) u_mux (
      .frac_en(frac_en), .fbit(fbit), .mf_first(msync_out),
      .slot(slot), .bitn(bitn), .frame(frame), .slot_mask(slot_mask),
      .pin_in(pin_in), .pin_out(ind_out), .pin_oe(ind_oe),
      .strobe(ts_strobe), .frac_vld(frac_vld), .frac_bit(frac_bit),
      .sig_vld(sig_vld), .sig_bit(sig_bit)
   );
endmodule

// File: rtl/t1si_checker.sv
module t1si_checker #(
   parameter int SLOTS = 24,
   parameter int NUM_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       timing_src,
   input logic             frac_en,
   input logic             sync_in,
   input logic [NUM_W-1:0] ind_out,
   input logic [NUM_W-1:0] ind_oe,
   input logic             ts_strobe,
   input logic             sync_out,
   input logic             msync_out,
   input logic             frac_vld,
   input logic             sig_vld
);
   AST_MSYNC_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
      msync_out |-> sync_out); // R9
   AST_NO_STROBE_FRAMING: assert property (@(posedge clk) disable iff (rst)
      sync_out |-> (!ts_strobe && !frac_vld && !sig_vld)); // R4
   AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
      !frac_en |-> (int'(ind_out) < SLOTS)); // R3
   AST_NORMAL_DIR: assert property (@(posedge clk) disable iff (rst)
      !frac_en |-> (&ind_oe)); // R3
   AST_FRAC_DIR: assert property (@(posedge clk) disable iff (rst)
      frac_en |-> (ind_oe[1:0] == 2'b00 && ind_oe[3:2] == 2'b11 && !ind_oe[4])); // R5
   AST_FRAC_GATE: assert property (@(posedge clk) disable iff (rst)
      frac_vld |-> ts_strobe); // R6
   AST_REALIGN: assert property (@(posedge clk) disable iff (rst)
      (timing_src == 2'd0 && sync_in) |=> !sync_out); // R12
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      (!frac_en && timing_src != 2'd0 && ts_strobe && int'(ind_out) != SLOTS - 1)
      |=> (frac_en || ind_out == $past(ind_out) + 1'b1)); // R4
endmodule

bind t1_slot_indicator t1si_checker #(.SLOTS(SLOTS), .NUM_W(NUM_W)) u_chk (
   .clk(clk), .rst(rst), .timing_src(timing_src), .frac_en(frac_en),
   .sync_in(sync_in), .ind_out(ind_out), .ind_oe(ind_oe),
   .ts_strobe(ts_strobe), .sync_out(sync_out), .msync_out(msync_out),
   .frac_vld(frac_vld), .sig_vld(sig_vld)
);

// File: tb/t1_slot_indicator_test.sv
module t1_slot_indicator_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  timing_src = 2'd1;
   logic        frac_en = 1'b0;
   logic        esf_mode = 1'b0;
   logic [23:0] slot_mask = '0;
   logic        sync_in = 1'b0;
   logic        msync_in = 1'b0;
   logic [1:0]  pin_in = '0;
   logic [4:0]  ind_out, ind_oe;
   logic        ts_strobe, sync_out, msync_out, sync_drive;
   logic        frac_vld, frac_bit, sig_vld, sig_bit;

   t1_slot_indicator uut (
      .clk(clk), .rst(rst), .timing_src(timing_src), .frac_en(frac_en),
      .esf_mode(esf_mode), .slot_mask(slot_mask), .sync_in(sync_in),
      .msync_in(msync_in), .pin_in(pin_in), .ind_out(ind_out), .ind_oe(ind_oe),
      .ts_strobe(ts_strobe), .sync_out(sync_out), .msync_out(msync_out),
      .sync_drive(sync_drive), .frac_vld(frac_vld), .frac_bit(frac_bit),
      .sig_vld(sig_vld), .sig_bit(sig_bit)
   );

   always #10 clk = ~clk;

   typedef struct packed {
      logic       in_rst, frac, ext;
      logic [4:0] ind, oe;
      logic       stb, so, mso, drv, fv, fb, sv, sb;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0, n_bad = 0;
   int   m_pos = 0, m_frame = 0;
   bit   done = 0;

   function automatic exp_t predict();
      exp_t e;
      int   slot, b, len;
      len = esf_mode ? 24 : 12;
      slot = (m_pos == 0) ? 0 : (m_pos - 1) / 8;
      b    = (m_pos == 0) ? 0 : (m_pos - 1) % 8;
      e = '0;
      e.in_rst = rst; e.frac = frac_en; e.ext = (timing_src == 2'd0);
      e.so  = (m_pos == 0);
      e.mso = (m_pos == 0) && (m_frame == 0);
      e.drv = (timing_src != 2'd0);
      if (!frac_en) begin
         e.ind = 5'(slot);
         e.oe  = 5'b11111;
         e.stb = (m_pos != 0) && (b == 7);
      end else begin
         e.oe  = 5'b01100;
         e.ind[2] = (m_pos != 0 && b < 5) ? slot[4 - b] : 1'b0;
         e.ind[3] = e.mso;
         e.stb = (m_pos != 0) && slot_mask[slot];
         e.fv  = e.stb;
         e.fb  = e.fv && pin_in[0];
         e.sv  = (m_pos != 0) && (b == 7) && (m_frame % 6 == 5);
         e.sb  = e.sv && pin_in[1];
      end
      if (len == 0) e.so = 1'b0;
      return e;
   endfunction

   function automatic void model_step();
      int len;
      len = esf_mode ? 24 : 12;
      if (rst) begin
         m_pos = 0; m_frame = 0;
      end else if (timing_src == 2'd0 && sync_in) begin
         if (msync_in)        m_frame = 0;
         else if (m_pos != 0) m_frame = (m_frame + 1 >= len) ? 0 : m_frame + 1;
         m_pos = 1;
      end else if (m_pos == 192) begin
         m_pos = 0;
         m_frame = (m_frame + 1 >= len) ? 0 : m_frame + 1;
      end else begin
         m_pos++;
      end
   endfunction

   // driver: one bit clock, expected item pushed after the edge settles
   task automatic tick();
      @(posedge clk);
      model_step();
      #5;
      exp_q.push_back(predict());
      @(negedge clk);
      #1;
      pin_in = 2'($urandom);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic chk(input string tag, input string what, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d time=%0t", tag, what, act, expv, $time);
      end
   endtask

   // monitor: pops and compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         if (e.in_rst) begin
            chk("R1", "sync_out", sync_out, e.so);
            chk("R1", "msync_out", msync_out, e.mso);
            chk("R1", "ind_out", ind_out, e.ind);
            chk("R1", "ts_strobe", ts_strobe, e.stb);
         end else begin
            chk(e.ext ? "R12" : "R2", "sync_out", sync_out, e.so);
            chk("R9", "msync_out", msync_out, e.mso);
            chk("R11", "sync_drive", sync_drive, e.drv);
            chk(e.frac ? "R5" : "R3", "ind_oe", ind_oe, e.oe);
            if (e.frac) begin
               chk("R7", "ind_out[2]", ind_out[2], e.ind[2]);
               chk("R8", "ind_out[3]", ind_out[3], e.ind[3]);
               chk("R5", "ind_out[4,1,0]", {ind_out[4], ind_out[1:0]},
                   {e.ind[4], e.ind[1:0]});
               chk("R6", "ts_strobe", ts_strobe, e.stb);
            end else begin
               chk(e.ext ? "R12" : "R3", "ind_out", ind_out, e.ind);
               chk("R4", "ts_strobe", ts_strobe, e.stb);
            end
            chk("R6", "frac_vld", frac_vld, e.fv);
            chk("R6", "frac_bit", frac_bit, e.fb);
            chk("R10", "sig_vld", sig_vld, e.sv);
            chk("R10", "sig_bit", sig_bit, e.sb);
         end
      end
   end

   task automatic pulse(input logic s, input logic ms);
      sync_in = s; msync_in = ms;
      tick();
      sync_in = 1'b0; msync_in = 1'b0;
   endtask

   initial begin
      // R1: reset state, then the first cycle after release
      run(3);
      rst = 1'b0;
      // R2 R3 R4 R9: normal mode, oscillator timing, 12-frame multiframe
      run(2 * 12 * 193 + 5);
      // R9: 24-frame multiframe with recovered line timing
      esf_mode = 1'b1; timing_src = 2'd2;
      run(24 * 193 + 7);
      // R5 R6 R7 R8 R10: fractional mode with a sparse irregular mask
      frac_en = 1'b1; slot_mask = 24'hA5_30_C9;
      run(24 * 193);
      // R6: empty and full masks, 12-frame multiframe
      esf_mode = 1'b0; slot_mask = 24'h000000;
      run(12 * 193);
      slot_mask = 24'hFFFFFF;
      run(3 * 193);
      // R11 R12: terminal-equipment timing with mid-frame realignment
      frac_en = 1'b0; timing_src = 2'd0;
      run(57);
      pulse(1'b1, 1'b0);
      run(500);
      pulse(1'b1, 1'b1);
      run(192);
      pulse(1'b1, 1'b0);            // sync landing exactly on a framing bit
      run(300);
      frac_en = 1'b1; slot_mask = 24'h0F00F3;
      pulse(1'b1, 1'b1);
      run(12 * 193);
      // R11: sync inputs ignored under internal timing (reserved code too)
      timing_src = 2'd1;
      pulse(1'b1, 1'b1);
      run(211);
      timing_src = 2'd3;
      pulse(1'b1, 1'b0);
      run(400);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule